// File: doc/BRIEF.md
# Watchdog Timer with Selectable Prescaler

This block is a system-monitor watchdog. Software controls it through one 8-bit control register and must keep restarting it. Once enabled, the watchdog counts clock cycles through a chain of three stages. A fixed pre-divider comes first, then a power-of-two prescaler picked by a 3-bit select code, then a wide final timer. If software lets the final timer overflow, the block raises a reset request for exactly one clock. The surrounding chip turns that request into an internal system reset.

Software restarts the count in one of two ways. It can write the register with the restart bit set, or it can move the enable bit from 0 to 1. A separate bit chooses whether the watchdog keeps running while the device reports it is idle. With the default parameters the final timer is 14 bits wide and the pre-divider is 12. The timeout is therefore 12 × 2^(sel+1) × 2^14 clock cycles.

Top module: `wdt_core`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `rd_data_o` reads 0x00 and `wdt_rst_o` is low. This means the watchdog starts disabled, with idle-run cleared and select code 0.
- R2: The control byte has this layout. Bit 7 is enable, bit 6 is restart, bit 5 is idle-run, and bits 2..0 are the select code. Readback returns enable, idle-run and select in those same positions. Bit 6 and bits 4..3 always read back as 0. The register changes only on a write.
- R3: Select code s gives a prescaler of 2^(s+1), so codes 000 to 111 divide by 2 up to 256. After a restart at clock edge E, with counting never paused, `wdt_rst_o` is high in the cycle after edge E + PRE_DIV × 2^(s+1) × 2^TIMER_W.
- R4: Each reset request lasts exactly one cycle. If the watchdog is left enabled and is not restarted, further requests follow at one full timeout period apart.
- R5: A write with bit 6 set zeroes the pre-divider, the prescaler and the final timer at the write's own clock edge. The next request then comes one full period after that edge.
- R6: While `idle_i` is high and idle-run is 0, no stage advances. The remaining time is kept and resumes when `idle_i` falls.
- R7: While idle-run is 1, counting goes on regardless of `idle_i`.
- R8: While enable is 0, the counters hold and no reset request is issued.
- R9: A write that takes enable from 0 to 1 zeroes all three stages, so a full period runs from that write's edge.
- R10: Asserting `rst` in the middle of a count disables the watchdog. No request comes until software enables it again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high system reset |
| idle_i | input | 1 | High while the device is in idle mode |
| wr_en_i | input | 1 | Write strobe for the control register |
| wr_data_i | input | 8 | Control byte to write |
| rd_data_o | output | 8 | Control register readback |
| wdt_rst_o | output | 1 | One-cycle internal reset request on timeout |

## Verification
Two situations are hard to reach from the ports. The first is a restart that arrives part-way through a period. The second is a pause that shifts a pending timeout. Each only shows up as a change in when the request appears.

The stimulus uses a small pre-divider and a narrow final timer, so that periods are a few hundred cycles. It then does three things. It issues a restart write, an idle stretch, or a disable-then-enable sequence at a known offset inside a running period. It predicts the exact cycle of the next request from that offset. A request at the un-restarted or un-paused time counts as an unexpected pulse.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W   = 8;
  localparam int SEL_W    = 3;
  localparam int EN_BIT   = 7;
  localparam int CLR_BIT  = 6;
  localparam int IDLE_BIT = 5;

  typedef struct packed {
    logic             en;
    logic             idle_en;
    logic [SEL_W-1:0] sel;
  } wdt_cfg_t;
endpackage

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output wdt_cfg_t          cfg,
  output logic              restart
);
  logic unused_bits;
  assign unused_bits = ^wr_data[4:3];

  // restart on explicit clear, or on enable going 0 -> 1
  assign restart = wr_en & (wr_data[CLR_BIT] | (wr_data[EN_BIT] & ~cfg.en));

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (wr_en) begin
      cfg.en      <= wr_data[EN_BIT];
      cfg.idle_en <= wr_data[IDLE_BIT];
      cfg.sel     <= wr_data[SEL_W-1:0];
    end
  end
endmodule

// File: rtl/wdt_div.sv
module wdt_div #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_bypass
      assign tick = run;
    end else begin : g_count
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt;

      assign tick = run && (cnt == LAST);

      always_ff @(posedge clk) begin
        if (rst || restart) begin
          cnt <= '0;
        end else if (run) begin
          cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             tick_in,
  input  logic [SEL_W-1:0] sel,
  output logic             tick_out
);
  localparam int CW = 2 ** SEL_W;
  logic [CW-1:0] cnt;
  logic [CW-1:0] mask;

  // low (sel+1) bits all ones marks the end of a 2^(sel+1) window
  always_comb begin
    for (int i = 0; i < CW; i++) begin
      mask[i] = (i <= int'(sel));
    end
  end

  assign tick_out = tick_in && ((cnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (tick_in) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int TIMER_W = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic tick_in,
  output logic expire
);
  logic [TIMER_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt    <= '0;
      expire <= 1'b0;
    end else begin
      expire <= tick_in && (&cnt);
      if (tick_in) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int PRE_DIV = 12,
  parameter int TIMER_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idle_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              wdt_rst_o
);
  wdt_cfg_t cfg;
  logic     restart;
  logic     run;
  logic     div_tick;
  logic     pre_tick;

  wdt_cfg_reg u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en_i),
    .wr_data (wr_data_i),
    .cfg     (cfg),
    .restart (restart)
  );

  assign run = cfg.en & (~idle_i | cfg.idle_en);

  wdt_div #(.DIV(PRE_DIV)) u_div (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .run     (run),
    .tick    (div_tick)
  );

  wdt_prescale #(.SEL_W(SEL_W)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart),
    .tick_in  (div_tick),
    .sel      (cfg.sel),
    .tick_out (pre_tick)
  );

  wdt_timer #(.TIMER_W(TIMER_W)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .tick_in (pre_tick),
    .expire  (wdt_rst_o)
  );

  always_comb begin
    rd_data_o                = '0;
    rd_data_o[EN_BIT]        = cfg.en;
    rd_data_o[IDLE_BIT]      = cfg.idle_en;
    rd_data_o[SEL_W-1:0]     = cfg.sel;
  end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
  input logic       clk,
  input logic       rst,
  input logic       idle_i,
  input logic       wr_en_i,
  input logic [7:0] rd_data_o,
  input logic       wdt_rst_o
);
  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (rd_data_o == 8'h00 && !wdt_rst_o)); // R1

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_data_o[6] == 1'b0 && rd_data_o[4:3] == 2'b00)); // R2

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> $stable(rd_data_o)); // R2

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
    wdt_rst_o |=> !wdt_rst_o); // R4

  AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (idle_i && !rd_data_o[5] && !wr_en_i) |=> !wdt_rst_o); // R6

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!rd_data_o[7] && !wr_en_i) |=> !wdt_rst_o); // R8
endmodule

bind wdt_core wdt_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .idle_i    (idle_i),
  .wr_en_i   (wr_en_i),
  .rd_data_o (rd_data_o),
  .wdt_rst_o (wdt_rst_o)
);

// File: tb/wdt_core_tb_top.sv
`timescale 1ns/1ps
module wdt_core_tb_top;
  localparam int D  = 3;
  localparam int TW = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       idle_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic [7:0] rd_data_o;
  logic       wdt_rst_o;

  int cyc = 0;
  int n_checks = 0;
  int n_errors = 0;
  int pulses = 0;
  int exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_core #(.PRE_DIV(D), .TIMER_W(TW)) dut_i (
    .clk(clk), .rst(rst), .idle_i(idle_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .wdt_rst_o(wdt_rst_o)
  );

  function automatic int period(int s);
    return D * (2 << s) * (1 << TW);
  endfunction

  // monitor: pops expected pulse cycles from the scoreboard
  always @(negedge clk) begin
    if (!rst && wdt_rst_o) begin
      pulses++;
      n_checks++;
      if (exp_q.size() == 0) begin
        n_errors++;
        $display("FAIL unexpected pulse: actual cycle %0d expected none", cyc);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (e != cyc) begin
          n_errors++;
          $display("FAIL %s pulse: actual cycle %0d expected %0d", t, cyc, e);
        end
      end
    end
  end

  task automatic push(int c, string t);
    exp_q.push_back(c);
    tag_q.push_back(t);
  endtask

  task automatic check(string t, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", t, act, exp);
    end
  endtask

  // write at a negedge; returns the clock edge that takes it
  task automatic wr(input logic [7:0] d, output int e);
    @(negedge clk);
    wr_en_i = 1'b1;
    wr_data_i = d;
    e = cyc + 1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic drain(string t, int limit);
    int stop = cyc + limit;
    while (exp_q.size() != 0 && cyc < stop) @(negedge clk);
    check({t, " all expected pulses seen"}, exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
  endtask

  initial begin
    #(200000 * 4);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: bench did not finish");
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    int e, c, p0;
    repeat (4) @(negedge clk);
    check("R1 readback in reset", rd_data_o, 8'h00);
    check("R1 no pulse in reset", wdt_rst_o, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 readback after reset", rd_data_o, 8'h00);

    // R2: field layout, restart and unused bits read 0
    wr(8'h7F, e);
    check("R2 readback of 0x7F", rd_data_o, 8'h27);
    wr(8'h00, e);
    check("R2 readback of 0x00", rd_data_o, 8'h00);

    // R3/R4: sel 0, two periodic pulses
    wr(8'h80, e);
    check("R2 readback enabled", rd_data_o, 8'h80);
    push(e + period(0), "R3 sel0");
    push(e + 2 * period(0), "R4 repeat");
    drain("R4", 400);
    wr(8'h00, e);

    // R3: sel 2
    wr(8'h82, e);
    push(e + period(2), "R3 sel2");
    drain("R3 sel2", 500);
    wr(8'h00, e);

    // R3: sel 7
    wr(8'h87, e);
    push(e + period(7), "R3 sel7");
    drain("R3 sel7", 13000);
    wr(8'h00, e);

    // R5: restart mid-period (sel 1)
    wr(8'h81, e);
    wait_cyc(e + 100);
    wr(8'hC1, c);
    check("R5 restart bit reads 0", rd_data_o, 8'h81);
    push(c + period(1), "R5 restart");
    drain("R5", 400);
    wr(8'h00, e);

    // R6: idle freezes with idle-run off
    wr(8'h80, e);
    wait_cyc(e + 20);
    idle_i = 1'b1;
    wait_cyc(e + 60);
    idle_i = 1'b0;
    push(e + period(0) + 40, "R6 idle freeze");
    drain("R6", 300);
    wr(8'h00, e);

    // R7: idle-run on keeps counting
    wr(8'hA0, e);
    wait_cyc(e + 20);
    idle_i = 1'b1;
    wait_cyc(e + 60);
    idle_i = 1'b0;
    push(e + period(0), "R7 idle run");
    drain("R7", 300);
    wr(8'h00, e);

    // R8: disable mid-count, no pulse
    wr(8'h80, e);
    wait_cyc(e + 50);
    p0 = pulses;
    wr(8'h00, c);
    wait_cyc(c + 300);
    check("R8 no pulse while disabled", pulses - p0, 0);

    // R9: enable rise restarts
    wr(8'h80, e);
    wait_cyc(e + 60);
    wr(8'h00, c);
    wait_cyc(c + 10);
    wr(8'h80, c);
    push(c + period(0), "R9 enable restart");
    drain("R9", 300);

    // R10: reset mid-count
    wait_cyc(cyc + 30);
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 readback after reset", rd_data_o, 8'h00);
    p0 = pulses;
    wait_cyc(cyc + 300);
    check("R10 no pulse after reset", pulses - p0, 0);

    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule